// File: doc/BRIEF.md
# Four-Context Barrel-Threaded Stack Processor

A 16-bit stack processor that keeps four complete execution contexts and issues one instruction per clock, taking the contexts in strict turn. Each context has its own program counter, top-of-stack register, data stack, return stack and pending-load flag. The ALU, the single memory read port and the write bus are shared by time slicing. Each context therefore behaves like a private processor clocked at one quarter of the rate, and its timing never depends on what the other three are doing. This makes cycle-exact polling loops in one context safe while the others run arbitrary code.

Every cycle the core presents one address on `mem_addr` and expects the word on `mem_rdata` within that cycle. That word is either the instruction of the context in turn or, in the second half of a load, the data being loaded. Stores appear on the write bus in the cycle of the storing instruction, and `slot` names the context issuing it. A per-context `restart` line is the only interrupt-like mechanism: it returns one stuck context to its start address without touching the others.

Top module: `barrel_stack_cpu`

## Requirements
- R1: `slot` steps through 0,1,2,3 and wraps, advancing once every clock. The context named by `slot` is the one whose instruction or load completes in that cycle, so each context gets exactly one slot every 4 cycles.
- R2: After reset, context c has PC = c*STRIDE (STRIDE=64), empty stacks, T=0 and no pending load. The first four cycles therefore fetch from 0, 64, 128 and 192, and `wr_en` stays low.
- R3: An instruction with bit 15 set pushes its low 15 bits, zero-extended, as the new T. The old T moves to N.
- R4: Bits 15:13 = 000 jump to the target in bits 12:0. Bits 15:13 = 010 call that target and push PC+1 on the return stack. Bits 15:13 = 001 pop T and jump only if the popped T was zero.
- R5: Bits 15:13 = 011 is an ALU instruction with these fields: bits 11:8 op; bit 7 loads PC from R; bit 6 copies the old T into the new N; bit 5 copies T into the new R; bit 4 stores; bits 3:2 and 1:0 are signed two-bit moves of the return and data stack pointers.
- R6: ALU op codes give the new T as follows: 0 T, 1 N, 2 T+N, 3 T&N, 4 T|N, 5 T^N, 6 ~T, 7 all ones if N==T, 8 all ones if N<T signed, 9 N-T, 10 T>>1 logical, 11 T<<1, 12 R, 13 data stack depth, 14 context number.
- R7: A store drives `wr_en` with `wr_addr`=T and `wr_data`=N in the cycle of that instruction, while `slot` holds the issuing context.
- R8: ALU op 15 starts a load. In the same context's next slot, four cycles later, `mem_addr` carries the low 13 bits of T, the returned word becomes T, and no instruction is consumed.
- R9: A context's instruction timing does not depend on the other contexts' code or restarts. A loop of k instructions that stores once per pass writes exactly every 4k cycles.
- R10: `restart[i]` sets context i back to its start address with empty stacks, T=0 and no pending load. A store by context i in that cycle is suppressed, and the other contexts are unaffected.
- R11: Stacks are private per context. The depth op returns only the executing context's own depth, and the context op returns its own number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 4 | Per-context emergency restart |
| slot | output | 2 | Context served in this cycle |
| mem_addr | output | 13 | Fetch or load address |
| mem_rdata | input | 16 | Word read at `mem_addr`, same cycle |
| wr_en | output | 1 | Store strobe |
| wr_addr | output | 16 | Store address (T) |
| wr_data | output | 16 | Store data (N) |

## Verification
The hardest case to reach is a restart that lands on a context which has left items on its stacks. Only then does it matter that the depth is cleared and not just the PC. The bench leaves each worker context halted with two items stacked, then restarts context 1 on a chosen slot and clears its depth result in memory. The rerun must store depth 0 again. Meanwhile a polling loop in context 3 must keep its 20-cycle write period through both this directed restart and random restarts of the other contexts.

// File: rtl/barrel_stack_cpu.sv
`timescale 1ns/1ps
module barrel_stack_cpu #(
  parameter int W      = 16,
  parameter int AW     = 13,
  parameter int DDEPTH = 16,
  parameter int RDEPTH = 16,
  parameter int STRIDE = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    restart,
  output logic [1:0]    slot,
  output logic [AW-1:0] mem_addr,
  input  logic [W-1:0]  mem_rdata,
  output logic          wr_en,
  output logic [W-1:0]  wr_addr,
  output logic [W-1:0]  wr_data
);
  localparam int DPW = $clog2(DDEPTH);
  localparam int RPW = $clog2(RDEPTH);

  logic [1:0]     ctx;
  logic [AW-1:0]  pc  [4];
  logic [W-1:0]   tos [4];
  logic [DPW-1:0] dsp [4];
  logic [RPW-1:0] rsp [4];
  logic [3:0]     ldp;
  logic [W-1:0]   dstk [4*DDEPTH];
  logic [W-1:0]   rstk [4*RDEPTH];

  wire [W-1:0] insn = mem_rdata;
  wire [W-1:0] t    = tos[ctx];
  wire [W-1:0] n    = dstk[{ctx, dsp[ctx]}];
  wire [W-1:0] r    = rstk[{ctx, rsp[ctx]}];
  wire         ld   = ldp[ctx];
  wire         kill = restart[ctx];
  wire [3:0]   op   = insn[11:8];
  wire [1:0]   rdm  = insn[3:2];
  wire [1:0]   ddm  = insn[1:0];

  logic [AW-1:0]  npc;
  logic [W-1:0]   nt, alu, rwd;
  logic [DPW-1:0] ndsp;
  logic [RPW-1:0] nrsp;
  logic           dwe, rwe, nld, st;

  always_comb begin
    case (op)
      4'd0:    alu = t;
      4'd1:    alu = n;
      4'd2:    alu = t + n;
      4'd3:    alu = t & n;
      4'd4:    alu = t | n;
      4'd5:    alu = t ^ n;
      4'd6:    alu = ~t;
      4'd7:    alu = {W{n == t}};
      4'd8:    alu = {W{$signed(n) < $signed(t)}};
      4'd9:    alu = n - t;
      4'd10:   alu = t >> 1;
      4'd11:   alu = t << 1;
      4'd12:   alu = r;
      4'd13:   alu = W'(dsp[ctx]);
      4'd14:   alu = W'(ctx);
      default: alu = t;
    endcase
  end

  always_comb begin
    npc  = pc[ctx] + 1'b1;
    nt   = t;
    ndsp = dsp[ctx];
    nrsp = rsp[ctx];
    dwe  = 1'b0;
    rwe  = 1'b0;
    rwd  = t;
    nld  = 1'b0;
    st   = 1'b0;
    if (ld) begin
      npc = pc[ctx];
      nt  = mem_rdata;
    end else if (insn[15]) begin
      nt   = {1'b0, insn[14:0]};
      ndsp = dsp[ctx] + 1'b1;
      dwe  = 1'b1;
    end else begin
      case (insn[14:13])
        2'd0: npc = insn[AW-1:0];
        2'd1: begin
          if (t == '0) npc = insn[AW-1:0];
          nt   = n;
          ndsp = dsp[ctx] - 1'b1;
        end
        2'd2: begin
          npc  = insn[AW-1:0];
          nrsp = rsp[ctx] + 1'b1;
          rwe  = 1'b1;
          rwd  = W'(pc[ctx] + 1'b1);
        end
        default: begin
          nt   = alu;
          ndsp = dsp[ctx] + {{(DPW-2){ddm[1]}}, ddm};
          nrsp = rsp[ctx] + {{(RPW-2){rdm[1]}}, rdm};
          dwe  = insn[6];
          rwe  = insn[5];
          st   = insn[4];
          nld  = (op == 4'd15);
          if (insn[7]) npc = r[AW-1:0];
        end
      endcase
    end
  end

  assign slot     = ctx;
  assign mem_addr = ld ? t[AW-1:0] : pc[ctx];
  assign wr_en    = st & ~kill;
  assign wr_addr  = t;
  assign wr_data  = n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx <= '0;
      ldp <= '0;
      for (int i = 0; i < 4; i++) begin
        pc[i]  <= AW'(i * STRIDE);
        tos[i] <= '0;
        dsp[i] <= '0;
        rsp[i] <= '0;
      end
    end else begin
      ctx <= ctx + 2'd1;
      for (int i = 0; i < 4; i++) begin
        if (restart[i]) begin
          pc[i]  <= AW'(i * STRIDE);
          tos[i] <= '0;
          dsp[i] <= '0;
          rsp[i] <= '0;
          ldp[i] <= 1'b0;
        end else if (ctx == 2'(i)) begin
          pc[i]  <= npc;
          tos[i] <= nt;
          dsp[i] <= ndsp;
          rsp[i] <= nrsp;
          ldp[i] <= nld;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && dwe && !kill) dstk[{ctx, ndsp}] <= t;
    if (rst_n && rwe && !kill) rstk[{ctx, nrsp}] <= rwd;
  end
endmodule

// File: rtl/barrel_stack_cpu_chk.sv
`timescale 1ns/1ps
module barrel_stack_cpu_chk #(
  parameter int AW     = 13,
  parameter int STRIDE = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    restart,
  input logic [1:0]    slot,
  input logic [AW-1:0] mem_addr,
  input logic          wr_en,
  input logic [3:0]    ldp
);
  assert_slot_rotates_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (slot == 2'($past(slot) + 2'd1)));

  assert_restart_refetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart[2'(slot + 2'd1)] |=> (mem_addr == AW'(32'(slot) * STRIDE)));

  assert_restart_no_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart[slot] |-> !wr_en);

  assert_load_phase_no_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ldp[slot] |-> !wr_en);
endmodule

bind barrel_stack_cpu barrel_stack_cpu_chk #(.AW(AW), .STRIDE(STRIDE)) chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .slot(slot),
  .mem_addr(mem_addr), .wr_en(wr_en), .ldp(ldp)
);

// File: tb/sim_barrel_stack_cpu.sv
`timescale 1ns/1ps
module sim_barrel_stack_cpu;
  localparam int AW = 13;
  localparam int STRIDE = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    restart = 4'b0;
  logic [1:0]    slot;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_rdata;
  logic          wr_en;
  logic [15:0]   wr_addr, wr_data;

  logic [15:0] mem [0:8191];
  assign mem_rdata = mem[mem_addr];

  barrel_stack_cpu u0 (
    .clk(clk), .rst_n(rst_n), .restart(restart), .slot(slot),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #10 clk = ~clk;

  int nvec = 0, nbad = 0, cyc = 0, last_spin = 0;
  bit spin_seen = 0;
  logic [15:0] last_val;
  logic [15:0] expv [3][10];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] f_alu(int op, logic [15:0] t, logic [15:0] n);
    case (op)
      0: return t;
      1: return n;
      2: return t + n;
      3: return t & n;
      4: return t | n;
      5: return t ^ n;
      6: return ~t;
      7: return (n == t) ? 16'hFFFF : 16'h0;
      8: return ($signed(n) < $signed(t)) ? 16'hFFFF : 16'h0;
      9: return n - t;
      10: return t >> 1;
      11: return t << 1;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] lit(logic [15:0] v); return {1'b1, v[14:0]}; endfunction
  function automatic logic [15:0] br(logic [2:0] k, int a); return {k, 13'(a)}; endfunction
  function automatic logic [15:0] alu(int op, bit ret, bit t2n, bit t2r, bit s, logic [1:0] rd, logic [1:0] dd);
    return {3'b011, 1'b0, 4'(op), ret, t2n, t2r, s, rd, dd};
  endfunction

  // store N to [T], keep N as T (R7); drop
  localparam logic [15:0] ST = {3'b011, 1'b0, 4'd1, 4'b0001, 2'b00, 2'b11};
  localparam logic [15:0] DR = {3'b011, 1'b0, 4'd1, 4'b0000, 2'b00, 2'b11};

  int pp;
  task automatic emit(input logic [15:0] w); mem[pp] = w; pp++; endtask

  task automatic build_worker(input int c);
    int res, l1, jzat, jmpat, callat, s;
    logic [15:0] a, b, v, z, pre;
    res = 16'h800 + c * 16;
    pp = c * STRIDE;
    emit(alu(13, 0, 1, 0, 0, 2'b00, 2'b01)); emit(lit(16'(res))); emit(ST); emit(DR);
    expv[c][0] = 16'h0;
    emit(alu(14, 0, 1, 0, 0, 2'b00, 2'b01)); emit(lit(16'(res + 1))); emit(ST); emit(DR);
    expv[c][1] = 16'(c);
    for (int k = 0; k < 3; k++) begin
      int op;
      bit inv;
      op = int'($urandom_range(0, 11));
      inv = $urandom_range(0, 1) == 1;
      a = 16'($urandom) & 16'h7FFF;
      b = 16'($urandom) & 16'h7FFF;
      if (k == 0) begin a = 16'h1234; b = 16'h1234; op = 7; end
      emit(lit(a)); emit(lit(b));
      if (inv) begin emit(alu(6, 0, 0, 0, 0, 2'b00, 2'b00)); b = ~b; end
      emit(alu(op, 0, 0, 0, 0, 2'b00, 2'b11));
      emit(lit(16'(res + 2 + k))); emit(ST); emit(DR);
      expv[c][2 + k] = f_alu(op, b, a);
    end
    pre = 16'($urandom);
    mem[16'h900 + c] = pre;
    emit(lit(16'(16'h900 + c))); emit(alu(15, 0, 0, 0, 0, 2'b00, 2'b00));
    emit(lit(16'(res + 5))); emit(ST); emit(DR);
    expv[c][5] = pre;
    z = ($urandom_range(0, 1) == 1) ? 16'h0 : (16'($urandom) & 16'h7FFF) | 16'h1;
    emit(lit(z)); jzat = pp; emit(16'h0);
    emit(lit(16'h111)); emit(lit(16'(res + 6))); emit(ST); emit(DR);
    jmpat = pp; emit(16'h0);
    l1 = pp;
    emit(lit(16'h222)); emit(lit(16'(res + 6))); emit(ST); emit(DR);
    mem[jzat] = br(3'b001, l1);
    mem[jmpat] = br(3'b000, pp);
    expv[c][6] = (z == 0) ? 16'h222 : 16'h111;
    callat = pp; emit(16'h0);
    emit(lit(16'h333)); emit(lit(16'(res + 8))); emit(ST); emit(DR);
    expv[c][8] = 16'h333;
    emit(lit(16'h0AA)); emit(lit(16'h055)); emit(alu(13, 0, 1, 0, 0, 2'b00, 2'b01));
    emit(lit(16'(res + 9))); emit(ST); emit(DR);
    expv[c][9] = 16'h2;
    emit(br(3'b000, pp));
    s = pp;
    mem[callat] = br(3'b010, s);
    v = 16'($urandom) & 16'h7FFF;
    emit(lit(v)); emit(lit(16'(res + 7))); emit(ST); emit(DR);
    emit(alu(0, 1, 0, 0, 0, 2'b11, 2'b00));
    expv[c][7] = v;
  endtask

  task automatic build_spin();
    pp = 3 * STRIDE;
    emit(lit(16'h0));
    emit(lit(16'h1)); emit(alu(2, 0, 0, 0, 0, 2'b00, 2'b11));
    emit(lit(16'hF00)); emit(ST); emit(br(3'b000, 3 * STRIDE + 1));
  endtask

  task automatic check_results();
    string tags [10] = '{"R11 depth", "R11 ctx", "R5 R6 alu", "R5 R6 alu", "R5 R6 alu",
                         "R8 load", "R4 jz", "R3 R4 call", "R4 return", "R11 depth2"};
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 10; k++) begin
        logic [15:0] got;
        got = mem[16'h800 + c * 16 + k];
        chk(got == expv[c][k], tags[k], 32'(got), 32'(expv[c][k]));
      end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      spin_seen = 0;
      cyc = 0;
    end else begin
      cyc++;
      if (wr_en) begin
        if (wr_addr == 16'hF00) begin
          chk(slot == 2'd3, "R7 spin slot", 32'(slot), 32'd3);
          if (spin_seen) begin
            chk(cyc - last_spin == 20, "R9 spin period", 32'(cyc - last_spin), 32'd20);
            chk(wr_data == last_val + 16'd1, "R6 spin count", 32'(wr_data), 32'(last_val + 16'd1));
          end else
            chk(wr_data == 16'd1, "R3 spin first", 32'(wr_data), 32'd1);
          spin_seen = 1;
          last_spin = cyc;
          last_val = wr_data;
        end else if (wr_addr[15:6] == 10'h020) begin
          chk(slot == wr_addr[5:4], "R7 store slot", 32'(slot), 32'(wr_addr[5:4]));
        end
        mem[wr_addr[12:0]] = wr_data;
      end
    end
  end

  initial begin
    #(20 * 100000);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int round = 0; round < 12; round++) begin
      rst_n = 1'b0;
      restart = 4'b0;
      for (int i = 0; i < 8192; i++) mem[i] = 16'h0;
      for (int c = 0; c < 3; c++) build_worker(c);
      build_spin();
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(slot == 0 && mem_addr == 0 && !wr_en, "R2 reset slot0", {slot, 3'b0, mem_addr}, 32'h0);
      for (int k = 1; k < 4; k++) begin
        @(negedge clk);
        chk(slot == 2'(k) && mem_addr == 13'(k * STRIDE) && !wr_en, "R2 reset fetch",
            {slot, 3'b0, mem_addr}, {2'(k), 3'b0, 13'(k * STRIDE)});
      end
      for (int k = 0; k < 8; k++) begin
        logic [1:0] prev;
        prev = slot;
        @(negedge clk);
        chk(slot == prev + 2'd1, "R1 rotation", 32'(slot), 32'(prev + 2'd1));
      end
      repeat (400) @(negedge clk);
      check_results();
      while (slot != 2'd0) @(negedge clk);
      mem[16'h810] = 16'hFFFF;
      restart = 4'b0010;
      @(negedge clk);
      restart = 4'b0;
      chk(slot == 2'd1 && mem_addr == 13'd64, "R10 restart fetch", 32'(mem_addr), 32'd64);
      repeat ($urandom_range(1, 120)) @(negedge clk);
      restart = ($urandom_range(0, 1) == 1) ? 4'b0001 : 4'b0100;
      @(negedge clk);
      restart = 4'b0;
      repeat (400) @(negedge clk);
      chk(mem[16'h810] == 16'h0, "R10 depth cleared", 32'(mem[16'h810]), 32'h0);
      check_results();
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule